// File: doc/BRIEF.md
# Three-level nested vectored interrupt controller

The controller chooses one interrupt at a time from ten vectors and offers it to a CPU. Each vector gathers several request sources, and any asserted source raises that vector's request. Each vector has one priority select bit. Clearing the bit puts the vector at the low level. Setting it puts the vector at the top level if it is one of the first two vectors, and at the middle level otherwise. Requests are level-sensitive. The controller never clears them; each peripheral clears its own flag.

Handlers can nest. The controller keeps one in-service flag per level. An acknowledge sets the flag for the level just granted, and a return clears the highest flag that is set. While a handler runs, a request is offered only if its level is strictly above the current in-service level. When several requests qualify, the higher level wins, and ties go to the lower vector address.

The offer to the CPU uses a valid/ready handshake. `irq_valid_o` and `irq_vec_o` are registered. They hold steady while `irq_ready_i` is low, even if the request that caused the offer goes away. The offer is consumed in the cycle where valid and ready are both high. The CPU can apply back-pressure for as long as it likes. A global enable blocks new offers when it is low, but it does not change the in-service state.

Top module: `irq_nest_ctrl`

## Requirements
- R1: Vector index k (0..9) is offered at address 3 + 8*k, so the addresses run from 0x0003 to 0x004B.
- R2: The in-service level is coded 0 = none, 1 = L, 2 = H, 3 = X. A vector whose priority bit is 0 is at L. A vector whose priority bit is 1 is at X for indices 0 and 1, and at H for indices 2..9.
- R3: A vector requests when any of its sources is high. Source s of vector k is bit k*NSRC+s of `src_req_i`.
- R4: Among the qualifying requests, the highest level wins. Among requests at the same level, the lowest index wins.
- R5: A request is offered only if its level is strictly greater than the current in-service level. Requests at an equal or lower level are held off.
- R6: While `irq_valid_o` is high and `irq_ready_i` is low, `irq_valid_o` and `irq_vec_o` do not change.
- R7: When valid and ready are both high, the in-service level becomes the offered level on the next cycle, and `irq_valid_o` goes low.
- R8: A pulse on `reti_i` clears the highest active in-service level, and the level below it becomes current again.
- R9: While `glb_en_i` is low, no new offer is raised, and the in-service level is unchanged.
- R10: After reset, no offer is pending and the in-service level is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_req_i | input | NVEC*NSRC | Level-sensitive request sources, grouped by vector |
| prio_sel_i | input | NVEC | Per-vector priority select bit |
| glb_en_i | input | 1 | Global interrupt enable |
| irq_valid_o | output | 1 | Interrupt offer pending |
| irq_vec_o | output | ADDR_W | Vector address of the offer |
| irq_ready_i | input | 1 | CPU acknowledge (consumes the offer) |
| reti_i | input | 1 | Return-from-interrupt pulse |
| isr_level_o | output | 2 | Current in-service level |

## Verification
The bench first drives every vector alone, through a different source each time and with both settings of its priority bit. This checks address generation, source merging and level mapping one at a time. It then sweeps every pair of vectors under all four combinations of their two priority bits, which separates "the higher level wins" from "the lower address wins". A nesting sequence checks that equal-level requests are refused, that a strictly higher level preempts, and that three returns unwind the levels in order. Separate runs check that an offer holds still under back-pressure and that a low enable blocks new offers while keeping the in-service state.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef logic [1:0] lvl_t;
  localparam lvl_t LVL_NONE = 2'd0;
  localparam lvl_t LVL_L    = 2'd1;
  localparam lvl_t LVL_H    = 2'd2;
  localparam lvl_t LVL_X    = 2'd3;
endpackage

// File: rtl/irq_req_merge.sv
module irq_req_merge #(
  parameter int NVEC = 10,
  parameter int NSRC = 3
) (
  input  logic [NVEC*NSRC-1:0] src_i,
  output logic [NVEC-1:0]      req_o
);
  genvar v;
  generate
    for (v = 0; v < NVEC; v++) begin : g_vec
      assign req_o[v] = |src_i[v*NSRC +: NSRC];
    end
  endgenerate
endmodule

// File: rtl/irq_level_map.sv
module irq_level_map
  import irq_pkg::*;
#(
  parameter int NVEC = 10,
  parameter int NTOP = 2
) (
  input  logic [NVEC-1:0]       sel_i,
  output lvl_t [NVEC-1:0]       lvl_o
);
  genvar v;
  generate
    for (v = 0; v < NVEC; v++) begin : g_map
      if (v < NTOP) begin : g_top
        assign lvl_o[v] = sel_i[v] ? LVL_X : LVL_L;
      end else begin : g_mid
        assign lvl_o[v] = sel_i[v] ? LVL_H : LVL_L;
      end
    end
  endgenerate
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int NVEC = 10,
  localparam int IDXW = $clog2(NVEC)
) (
  input  logic [NVEC-1:0] req_i,
  input  lvl_t [NVEC-1:0] lvl_i,
  input  lvl_t            cur_i,
  output logic            found_o,
  output logic [IDXW-1:0] idx_o,
  output lvl_t            lvl_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    lvl_o   = LVL_NONE;
    // scan downward so an equal level at a lower index replaces the holder
    for (int v = NVEC - 1; v >= 0; v--) begin
      if (req_i[v] && (lvl_i[v] > cur_i) && (lvl_i[v] >= lvl_o)) begin
        found_o = 1'b1;
        idx_o   = IDXW'(v);
        lvl_o   = lvl_i[v];
      end
    end
  end
endmodule

// File: rtl/irq_inservice.sv
module irq_inservice
  import irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ack_i,
  input  lvl_t ack_lvl_i,
  input  logic reti_i,
  output lvl_t cur_o
);
  logic [2:0] act_q, act_d;

  always_comb begin
    act_d = act_q;
    if (reti_i) begin
      if (act_q[2])      act_d[2] = 1'b0;
      else if (act_q[1]) act_d[1] = 1'b0;
      else               act_d[0] = 1'b0;
    end
    if (ack_i) begin
      case (ack_lvl_i)
        LVL_L:   act_d[0] = 1'b1;
        LVL_H:   act_d[1] = 1'b1;
        LVL_X:   act_d[2] = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= '0;
    else        act_q <= act_d;
  end

  always_comb begin
    if (act_q[2])      cur_o = LVL_X;
    else if (act_q[1]) cur_o = LVL_H;
    else if (act_q[0]) cur_o = LVL_L;
    else               cur_o = LVL_NONE;
  end

  // R8
  reti_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && !ack_i && cur_o != LVL_NONE) |=> (cur_o < $past(cur_o)));
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
  import irq_pkg::*;
#(
  parameter int NVEC   = 10,
  parameter int NSRC   = 3,
  parameter int NTOP   = 2,
  parameter int ADDR_W = 16,
  parameter int BASE   = 3,
  parameter int STEP   = 8,
  localparam int IDXW  = $clog2(NVEC)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NVEC*NSRC-1:0]   src_req_i,
  input  logic [NVEC-1:0]        prio_sel_i,
  input  logic                   glb_en_i,
  output logic                   irq_valid_o,
  output logic [ADDR_W-1:0]      irq_vec_o,
  input  logic                   irq_ready_i,
  input  logic                   reti_i,
  output logic [1:0]             isr_level_o
);
  logic [NVEC-1:0] req;
  lvl_t [NVEC-1:0] lvl;
  lvl_t            cur;
  logic            found;
  logic [IDXW-1:0] win_idx;
  lvl_t            win_lvl;
  logic            vld_q;
  logic [ADDR_W-1:0] vec_q;
  lvl_t            lvl_q;
  logic            take;

  irq_req_merge #(.NVEC(NVEC), .NSRC(NSRC)) u_merge (
    .src_i(src_req_i), .req_o(req));

  irq_level_map #(.NVEC(NVEC), .NTOP(NTOP)) u_map (
    .sel_i(prio_sel_i), .lvl_o(lvl));

  irq_arbiter #(.NVEC(NVEC)) u_arb (
    .req_i(req), .lvl_i(lvl), .cur_i(cur),
    .found_o(found), .idx_o(win_idx), .lvl_o(win_lvl));

  assign take = vld_q && irq_ready_i;

  irq_inservice u_isr (
    .clk(clk), .rst_n(rst_n), .ack_i(take), .ack_lvl_i(lvl_q),
    .reti_i(reti_i), .cur_o(cur));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      vec_q <= '0;
      lvl_q <= LVL_NONE;
    end else if (take) begin
      vld_q <= 1'b0;
    end else if (!vld_q && glb_en_i && found) begin
      vld_q <= 1'b1;
      vec_q <= ADDR_W'(BASE) + ADDR_W'(STEP) * ADDR_W'(win_idx);
      lvl_q <= win_lvl;
    end
  end

  assign irq_valid_o = vld_q;
  assign irq_vec_o   = vec_q;
  assign isr_level_o = cur;

  // R6
  offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !irq_ready_i) |=> (vld_q && $stable(vec_q)));
  // R5
  strictly_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> (lvl_q > cur));
  // R7
  ack_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !reti_i) |=> (!vld_q && cur == $past(lvl_q)));
  // R9
  enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!glb_en_i && !vld_q) |=> !vld_q);
  // R1
  vec_grid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> (((vec_q - ADDR_W'(BASE)) % ADDR_W'(STEP)) == '0));
endmodule

// File: tb/irq_nest_ctrl_bench.sv
module irq_nest_ctrl_bench;
  localparam int NV = 10;
  localparam int NS = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NV*NS-1:0] src = '0;
  logic [NV-1:0] prio = '0;
  logic en = 1'b1;
  logic valid;
  logic [15:0] vec;
  logic ready = 1'b0;
  logic reti = 1'b0;
  logic [1:0] lvl;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  irq_nest_ctrl u_irq_nest_ctrl (
    .clk(clk), .rst_n(rst_n), .src_req_i(src), .prio_sel_i(prio),
    .glb_en_i(en), .irq_valid_o(valid), .irq_vec_o(vec),
    .irq_ready_i(ready), .reti_i(reti), .isr_level_o(lvl));

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_lvl(input int k, input logic p);
    if (!p) return 1;
    return (k < 2) ? 3 : 2;
  endfunction

  function automatic int exp_addr(input int k);
    return 3 + 8 * k;
  endfunction

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // consume the offer with requests cleared, then report level
  task automatic take_offer();
    src = '0;
    ready = 1'b1;
    tick(1);
    ready = 1'b0;
  endtask

  task automatic do_reti();
    reti = 1'b1;
    tick(1);
    reti = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    tick(2);
    // R10 reset state
    chk(valid == 1'b0, "R10 valid", int'(valid), 0);
    chk(lvl == 2'd0, "R10 level", int'(lvl), 0);
    rst_n = 1'b1;
    tick(2);
    chk(valid == 1'b0, "R10 idle", int'(valid), 0);

    // R1 R2 R3: each vector alone, both priority settings
    for (int k = 0; k < NV; k++) begin
      for (int p = 0; p < 2; p++) begin
        prio = '0;
        prio[k] = p[0];
        src = '0;
        src[k*NS + ((k + p) % NS)] = 1'b1;
        tick(2);
        chk(valid == 1'b1, "R3 valid", int'(valid), 1);
        chk(int'(vec) == exp_addr(k), "R1 addr", int'(vec), exp_addr(k));
        take_offer();
        chk(int'(lvl) == exp_lvl(k, p[0]), "R2 level", int'(lvl), exp_lvl(k, p[0]));
        chk(valid == 1'b0, "R7 drop", int'(valid), 0);
        do_reti();
        chk(lvl == 2'd0, "R8 unwind", int'(lvl), 0);
      end
    end

    // R4: every pair, every priority combination
    for (int i = 0; i < NV; i++) begin
      for (int j = i + 1; j < NV; j++) begin
        for (int p = 0; p < 4; p++) begin
          int li, lj, w;
          prio = '0;
          prio[i] = p[0];
          prio[j] = p[1];
          li = exp_lvl(i, p[0]);
          lj = exp_lvl(j, p[1]);
          w = (lj > li) ? j : i;
          src = '0;
          src[i*NS] = 1'b1;
          src[j*NS + NS - 1] = 1'b1;
          tick(2);
          chk(int'(vec) == exp_addr(w), "R4 winner", int'(vec), exp_addr(w));
          take_offer();
          do_reti();
        end
      end
    end

    // R5 nesting and R8 unwind
    prio = '0;
    src = '0;
    src[9*NS] = 1'b1;
    tick(2);
    take_offer();
    chk(lvl == 2'd1, "R7 level L", int'(lvl), 1);
    src[2*NS + 1] = 1'b1;
    tick(3);
    chk(valid == 1'b0, "R5 equal refused", int'(valid), 0);
    prio[2] = 1'b1;
    tick(2);
    chk(valid == 1'b1 && int'(vec) == exp_addr(2), "R5 preempt", int'(vec), exp_addr(2));
    take_offer();
    chk(lvl == 2'd2, "R7 level H", int'(lvl), 2);
    src[5*NS] = 1'b1;
    prio[5] = 1'b1;
    tick(3);
    chk(valid == 1'b0, "R5 H refused", int'(valid), 0);
    src = '0;
    src[1*NS + 2] = 1'b1;
    prio[1] = 1'b1;
    tick(2);
    chk(int'(vec) == exp_addr(1), "R5 X preempt", int'(vec), exp_addr(1));
    take_offer();
    chk(lvl == 2'd3, "R7 level X", int'(lvl), 3);
    do_reti();
    chk(lvl == 2'd2, "R8 back to H", int'(lvl), 2);
    do_reti();
    chk(lvl == 2'd1, "R8 back to L", int'(lvl), 1);
    do_reti();
    chk(lvl == 2'd0, "R8 back to none", int'(lvl), 0);

    // R6 hold under back-pressure
    prio = '0;
    src = '0;
    src[5*NS] = 1'b1;
    tick(2);
    chk(int'(vec) == exp_addr(5), "R6 first", int'(vec), exp_addr(5));
    src = '0;
    src[0] = 1'b1;
    prio[0] = 1'b1;
    tick(4);
    chk(valid == 1'b1 && int'(vec) == exp_addr(5), "R6 held", int'(vec), exp_addr(5));
    take_offer();
    chk(lvl == 2'd1, "R6 acked L", int'(lvl), 1);

    // R9 enable low blocks offers and keeps in-service state
    en = 1'b0;
    src[0] = 1'b1;
    tick(4);
    chk(valid == 1'b0, "R9 blocked", int'(valid), 0);
    chk(lvl == 2'd1, "R9 kept", int'(lvl), 1);
    en = 1'b1;
    tick(2);
    chk(valid == 1'b1 && int'(vec) == exp_addr(0), "R9 resumed", int'(vec), exp_addr(0));
    take_offer();
    do_reti();
    do_reti();
    chk(lvl == 2'd0, "R8 final", int'(lvl), 0);

    finish_run();
  end
endmodule